// File: doc/BRIEF.md
# Virtual chip flash mapper

This block turns a host nibble address into a byte address within a 128 KB flash that is cut into eight 16 KB blocks, numbered 0 to 7. A small table of up to eight ROM entries is written through a load port. Each entry carries a host base address, a size code and a starting block number. When an entry is written, the block works out the entry's upper limit and its flash byte offset in the same step. A lookup therefore needs only compares and one add, with no search arithmetic. A ROM larger than one block fills consecutive blocks that start at its entry's block number. The entries can sit in any order relative to their blocks.

A control word decides which blocks may answer at all. It is written at one fixed host address: 0 unmaps everything, 1 maps blocks 1 to 7, and 3 maps all eight blocks. The lower 8 KB of block 0 holds firmware and never answers. Its upper 8 KB can host a hidden ROM. A separate enable switches on a fixed 32 KB window at host address 0xE0000. The first half of that window comes from block 6 and the second half from block 7.

A lookup moves through three named states. ST_IDLE accepts a request (transition IDLE->MATCH). ST_MATCH resolves the captured address and registers the result (MATCH->REPLY). ST_REPLY presents the result for one cycle and then returns to ST_IDLE (REPLY->IDLE).

Top module: `vchip_flash_mapper`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and resp_hit are 0, the control word is "unmapped" and every table entry is empty, so every lookup misses until the control word is written.
- R2: A request is taken at a clock edge where req_valid and req_ready are both 1. req_ready is then 0 for two cycles. resp_valid is 1 only in the second cycle after acceptance, and only for that one cycle.
- R3: An entry hits when base <= address < base + size. Size code 0xA means 32K nibbles (16 KB), 0x9 means 64K nibbles and 0x8 means 128K nibbles. On a hit, resp_faddr = block x 0x4000 + (address - base) / 2.
- R4: An entry becomes empty and never hits in three cases: it is written with cfg_valid = 0, its size code lies outside 0x8..0xA, or its span would run past block 7.
- R5: A ROM that spans several blocks continues into the consecutive blocks that follow its starting block.
- R6: When several entries qualify, the lowest table index wins. An entry whose target block is unmapped does not qualify, so a lower-priority entry or the fixed window can answer instead.
- R7: A control write takes effect only at host address 0x2C000. Data 1 maps blocks 1..7, data 3 maps blocks 0..7, and any other value unmaps all blocks. Writes to any other address are ignored.
- R8: Flash bytes below 0x2000 never hit. The upper half of block 0 hits only when control value 3 is in force.
- R9: When the fixed window is enabled, host addresses 0xE0000..0xEFFFF map to 0x18000 + (address - 0xE0000) / 2, gated like blocks 6 and 7. Table entries take precedence over this window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | 3 | Table index written |
| cfg_valid | input | 1 | 1 to fill the entry, 0 to empty it |
| cfg_base | input | 20 | Entry host base nibble address |
| cfg_size | input | 4 | Entry size code |
| cfg_chip | input | 3 | Entry starting flash block |
| cfg_hw_we | input | 1 | Write the fixed-window enable |
| cfg_hw_en | input | 1 | Fixed-window enable value |
| ctl_wr | input | 1 | Host write strobe for the control word |
| ctl_addr | input | 20 | Host write address |
| ctl_data | input | 4 | Host write data |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 20 | Host nibble address to translate |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Result is present |
| resp_hit | output | 1 | Address maps to flash |
| resp_faddr | output | 17 | Flash byte address |

## Verification
A stale or mis-derived table limit shows up as a wrong hit at a block boundary. That error appears in the reply to the first lookup that crosses the boundary. A control word that is held wrongly turns hits into misses, or the reverse, and shows in the very next reply. A wrong offset shows as an address that is off by a multiple of 0x4000. A fault in the state register shows as a missing reply, or a reply with the wrong timing, two cycles after a request. Randomly generated tables with overlapping entries, boundary addresses and every control value expose each of these at the ports.

// File: rtl/vcfm_pkg.sv
package vcfm_pkg;
    localparam int HADDR_W      = 20;
    localparam int FADDR_W      = 17;
    localparam int NBLK         = 8;
    localparam int BLK_W        = $clog2(NBLK);
    localparam int BLK_BYTE_LOG = FADDR_W - BLK_W;
    localparam int CODE_W       = 4;
    localparam int CODE_ONE_BLK = 10;
    localparam int CODE_MIN     = 8;
    localparam int RESV_BYTES   = 'h2000;

    typedef enum logic [1:0] {ST_IDLE, ST_MATCH, ST_REPLY} xl_state_t;
    typedef enum logic [1:0] {MAP_NONE, MAP_UPPER, MAP_ALL} map_mode_t;

    typedef struct packed {
        logic               valid;
        logic [HADDR_W:0]   base;
        logic [HADDR_W:0]   limit;
        logic [FADDR_W-1:0] offset;
    } map_entry_t;

    function automatic logic [NBLK-1:0] mode_mask(input map_mode_t m);
        logic [NBLK-1:0] r;
        unique case (m)
            MAP_ALL:   r = '1;
            MAP_UPPER: r = {{(NBLK-1){1'b1}}, 1'b0};
            default:   r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/vcfm_entry_table.sv
module vcfm_entry_table
    import vcfm_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_valid,
    input  logic [HADDR_W-1:0] cfg_base,
    input  logic [CODE_W-1:0]  cfg_size,
    input  logic [BLK_W-1:0]   cfg_chip,
    input  logic               cfg_hw_we,
    input  logic               cfg_hw_en,
    output map_entry_t         tbl_o [N_ENTRIES],
    output logic               hw_on_o
);
    map_entry_t new_entry;
    logic       code_ok;
    int         span_sh;

    // Limit and flash offset are derived once, at load time
    always_comb begin
        code_ok = (int'(cfg_size) >= CODE_MIN) && (int'(cfg_size) <= CODE_ONE_BLK);
        span_sh = code_ok ? (CODE_ONE_BLK - int'(cfg_size)) : 0;
        new_entry.valid  = cfg_valid && code_ok &&
                           ((int'(cfg_chip) + (1 << span_sh)) <= NBLK);
        new_entry.base   = {1'b0, cfg_base};
        new_entry.limit  = {1'b0, cfg_base} +
                           ((HADDR_W+1)'(1) << (BLK_BYTE_LOG + 1 + span_sh));
        new_entry.offset = FADDR_W'(cfg_chip) << BLK_BYTE_LOG;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) tbl_o[i] <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < N_ENTRIES; i++)
                if (cfg_idx == IDX_W'(i)) tbl_o[i] <= new_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         hw_on_o <= 1'b0;
        else if (cfg_hw_we) hw_on_o <= cfg_hw_en;
    end

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_chk
        // R4: a stored entry always spans a non-empty, block-aligned range
        assert_entry_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
            tbl_o[g].valid |-> (tbl_o[g].limit > tbl_o[g].base &&
                                tbl_o[g].offset[BLK_BYTE_LOG-1:0] == '0));
    end
endmodule

// File: rtl/vcfm_ctl.sv
module vcfm_ctl
    import vcfm_pkg::*;
#(
    parameter logic [HADDR_W-1:0] CTL_ADDR = 20'h2C000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [HADDR_W-1:0] waddr,
    input  logic [3:0]         wdata,
    output logic [NBLK-1:0]    blk_mask
);
    map_mode_t mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        if (wr && waddr == CTL_ADDR) begin
            unique case (wdata)
                4'd1:    mode_d = MAP_UPPER;
                4'd3:    mode_d = MAP_ALL;
                default: mode_d = MAP_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MAP_NONE;
        else        mode_q <= mode_d;
    end

    assign blk_mask = mode_mask(mode_q);

    // R7: writes elsewhere leave the mapping untouched
    assert_ctl_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && waddr != CTL_ADDR) |=> $stable(blk_mask));
    // R7: a zero write unmaps every block
    assert_ctl_unmap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && waddr == CTL_ADDR && wdata == 4'd0) |=> (blk_mask == '0));
endmodule

// File: rtl/vcfm_match.sv
module vcfm_match
    import vcfm_pkg::*;
#(
    parameter int                 N_ENTRIES    = 8,
    parameter logic [HADDR_W-1:0] HW_BASE      = 20'hE0000,
    parameter int                 HW_FIRST_BLK = 6
) (
    input  logic [HADDR_W-1:0] addr,
    input  map_entry_t         tbl [N_ENTRIES],
    input  logic [NBLK-1:0]    blk_mask,
    input  logic               hw_on,
    output logic               hit,
    output logic [FADDR_W-1:0] faddr
);
    localparam int               HW_BLOCKS = 2;
    localparam int               HW_NIB    = HW_BLOCKS << (BLK_BYTE_LOG + 1);
    localparam logic [HADDR_W:0] HW_LIMIT  = {1'b0, HW_BASE} + (HADDR_W+1)'(HW_NIB);

    logic [N_ENTRIES-1:0] qual;
    logic [FADDR_W-1:0]   foff [N_ENTRIES];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        logic               in_rng;
        logic [HADDR_W-1:0] diff;
        assign in_rng  = tbl[g].valid && ({1'b0, addr} >= tbl[g].base) &&
                         ({1'b0, addr} < tbl[g].limit);
        assign diff    = addr - tbl[g].base[HADDR_W-1:0];
        assign foff[g] = tbl[g].offset + FADDR_W'(diff >> 1);
        assign qual[g] = in_rng && blk_mask[foff[g][FADDR_W-1 -: BLK_W]] &&
                         (foff[g] >= FADDR_W'(RESV_BYTES));
    end

    logic               hw_in, hw_ok;
    logic [FADDR_W-1:0] hw_off;
    assign hw_in  = hw_on && (addr >= HW_BASE) && ({1'b0, addr} < HW_LIMIT);
    assign hw_off = FADDR_W'(HW_FIRST_BLK << BLK_BYTE_LOG) + FADDR_W'((addr - HW_BASE) >> 1);
    assign hw_ok  = hw_in && blk_mask[hw_off[FADDR_W-1 -: BLK_W]];

    // Fixed window lowest, then entries from highest index down
    always_comb begin
        hit   = hw_ok;
        faddr = hw_ok ? hw_off : '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (qual[i]) begin
                hit   = 1'b1;
                faddr = foff[i];
            end
        end
    end
endmodule

// File: rtl/vchip_flash_mapper.sv
module vchip_flash_mapper
    import vcfm_pkg::*;
#(
    parameter int                 N_ENTRIES    = 8,
    parameter logic [HADDR_W-1:0] CTL_ADDR     = 20'h2C000,
    parameter logic [HADDR_W-1:0] HW_BASE      = 20'hE0000,
    parameter int                 HW_FIRST_BLK = 6,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_valid,
    input  logic [HADDR_W-1:0] cfg_base,
    input  logic [CODE_W-1:0]  cfg_size,
    input  logic [BLK_W-1:0]   cfg_chip,
    input  logic               cfg_hw_we,
    input  logic               cfg_hw_en,
    input  logic               ctl_wr,
    input  logic [HADDR_W-1:0] ctl_addr,
    input  logic [3:0]         ctl_data,
    input  logic               req_valid,
    input  logic [HADDR_W-1:0] req_addr,
    output logic               req_ready,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic [FADDR_W-1:0] resp_faddr
);
    map_entry_t         tbl [N_ENTRIES];
    logic               hw_on;
    logic [NBLK-1:0]    blk_mask;
    logic               m_hit;
    logic [FADDR_W-1:0] m_faddr;

    vcfm_entry_table #(.N_ENTRIES(N_ENTRIES)) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_chip(cfg_chip),
        .cfg_hw_we(cfg_hw_we), .cfg_hw_en(cfg_hw_en),
        .tbl_o(tbl), .hw_on_o(hw_on)
    );

    vcfm_ctl #(.CTL_ADDR(CTL_ADDR)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .wr(ctl_wr), .waddr(ctl_addr), .wdata(ctl_data),
        .blk_mask(blk_mask)
    );

    xl_state_t          state, nxt;
    logic [HADDR_W-1:0] addr_q;
    logic               hit_q;
    logic [FADDR_W-1:0] faddr_q;

    vcfm_match #(.N_ENTRIES(N_ENTRIES), .HW_BASE(HW_BASE), .HW_FIRST_BLK(HW_FIRST_BLK)) u_match (
        .addr(addr_q), .tbl(tbl), .blk_mask(blk_mask), .hw_on(hw_on),
        .hit(m_hit), .faddr(m_faddr)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = ST_MATCH;
            ST_MATCH: nxt = ST_REPLY;
            ST_REPLY: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            hit_q   <= 1'b0;
            faddr_q <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) addr_q <= req_addr;
            if (state == ST_MATCH) begin
                hit_q   <= m_hit;
                faddr_q <= m_faddr;
            end
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign resp_valid = (state == ST_REPLY);
    assign resp_hit   = resp_valid & hit_q;
    assign resp_faddr = faddr_q;

    // R2: reply two cycles after acceptance, one cycle wide
    assert_accept_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 resp_valid);
    assert_reply_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    // R8: firmware area never reaches the host
    assert_no_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> (resp_faddr >= FADDR_W'(RESV_BYTES)));
endmodule

// File: tb/vchip_flash_mapper_test.sv
module vchip_flash_mapper_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_ENT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_valid = 0, cfg_hw_we = 0, cfg_hw_en = 0;
    logic [2:0]  cfg_idx = 0, cfg_chip = 0;
    logic [19:0] cfg_base = 0;
    logic [3:0]  cfg_size = 0;
    logic        ctl_wr = 0;
    logic [19:0] ctl_addr = 0;
    logic [3:0]  ctl_data = 0;
    logic        req_valid = 0;
    logic [19:0] req_addr = 0;
    logic        req_ready, resp_valid, resp_hit;
    logic [16:0] resp_faddr;

    int checks = 0;
    int fails = 0;

    logic        m_valid [N_ENT];
    logic [19:0] m_base  [N_ENT];
    logic [3:0]  m_code  [N_ENT];
    logic [2:0]  m_chip  [N_ENT];
    int          m_mode = 0;
    logic        m_hw = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vchip_flash_mapper uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_chip(cfg_chip),
        .cfg_hw_we(cfg_hw_we), .cfg_hw_en(cfg_hw_en),
        .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_data(ctl_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_faddr(resp_faddr)
    );

    function automatic logic [7:0] model_mask();
        if (m_mode == 3) return 8'hFF;
        if (m_mode == 1) return 8'hFE;
        return 8'h00;
    endfunction

    // Returns {hit, flash address}
    function automatic logic [17:0] model(input logic [19:0] a);
        logic [17:0] r = '0;
        logic [7:0]  mk = model_mask();
        if (m_hw && a >= 20'hE0000 && a <= 20'hEFFFF) begin
            logic [16:0] o = 17'h18000 + 17'((a - 20'hE0000) >> 1);
            if (mk[o[16:14]]) r = {1'b1, o};
        end
        for (int i = N_ENT - 1; i >= 0; i--) begin
            int c = int'(m_code[i]);
            if (m_valid[i] && c >= 8 && c <= 10 && (int'(m_chip[i]) + (1 << (10 - c))) <= 8) begin
                logic [20:0] lim = {1'b0, m_base[i]} + (21'(1) << (25 - c));
                if (a >= m_base[i] && {1'b0, a} < lim) begin
                    logic [16:0] o = 17'(int'(m_chip[i]) * 'h4000) + 17'((a - m_base[i]) >> 1);
                    if (mk[o[16:14]] && o >= 17'h2000) r = {1'b1, o};
                end
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_entry(input int idx, input logic v, input logic [19:0] b,
                              input logic [3:0] code, input logic [2:0] chip);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_valid = v; cfg_base = b; cfg_size = code; cfg_chip = chip;
        @(negedge clk);
        cfg_we = 0;
        m_valid[idx] = v; m_base[idx] = b; m_code[idx] = code; m_chip[idx] = chip;
    endtask

    task automatic set_hw(input logic en);
        @(negedge clk);
        cfg_hw_we = 1; cfg_hw_en = en;
        @(negedge clk);
        cfg_hw_we = 0;
        m_hw = en;
    endtask

    task automatic write_ctl(input logic [19:0] a, input logic [3:0] d);
        @(negedge clk);
        ctl_wr = 1; ctl_addr = a; ctl_data = d;
        @(negedge clk);
        ctl_wr = 0;
        if (a == 20'h2C000) m_mode = (d == 4'd1) ? 1 : (d == 4'd3) ? 3 : 0;
    endtask

    task automatic lookup(input logic [19:0] a, input string req);
        logic [17:0] e = model(a);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        check(!req_ready && !resp_valid, "R2 busy after accept", {req_ready, resp_valid}, 0);
        @(negedge clk);
        check(resp_valid, "R2 reply cycle", resp_valid, 1);
        check(resp_hit == e[17] && (!e[17] || resp_faddr == e[16:0]), req,
              {resp_hit, 3'b0, resp_faddr}, {e[17], 3'b0, e[16:0]});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < N_ENT; i++) begin
            m_valid[i] = 0; m_base[i] = 0; m_code[i] = 0; m_chip[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(req_ready && !resp_valid && !resp_hit, "R1 reset outputs",
              {req_ready, resp_valid, resp_hit}, 3'b100);
        load_entry(0, 1, 20'h20000, 4'hA, 3'd1);
        lookup(20'h20000, "R1 unmapped after reset");

        write_ctl(20'h2C000, 4'd1);
        lookup(20'h20000, "R3 first nibble");
        lookup(20'h27FFF, "R3 last nibble");
        lookup(20'h28000, "R3 past limit");
        lookup(20'h1FFFF, "R3 below base");

        load_entry(1, 1, 20'h30000, 4'h9, 3'd2);
        lookup(20'h38000, "R5 second block");
        lookup(20'h3FFFF, "R5 end of span");
        load_entry(3, 1, 20'hA0000, 4'h8, 3'd4);
        lookup(20'hBFFFF, "R5 four-block span end");

        load_entry(2, 1, 20'h50000, 4'h7, 3'd1);
        lookup(20'h50000, "R4 bad size code");
        load_entry(4, 1, 20'h60000, 4'h9, 3'd7);
        lookup(20'h60000, "R4 span past block 7");

        load_entry(5, 1, 20'h20000, 4'h9, 3'd4);
        lookup(20'h20010, "R6 lower index wins");
        lookup(20'h28000, "R6 second entry answers");

        write_ctl(20'h2C001, 4'd0);
        lookup(20'h20000, "R7 other address ignored");
        write_ctl(20'h2C000, 4'd0);
        lookup(20'h20000, "R7 value 0 unmaps");
        write_ctl(20'h2C000, 4'd2);
        lookup(20'h20000, "R7 value 2 unmaps");
        write_ctl(20'h2C000, 4'd3);
        lookup(20'h20000, "R7 value 3 maps");

        load_entry(6, 1, 20'h80000, 4'hA, 3'd0);
        lookup(20'h80000, "R8 firmware half");
        lookup(20'h83FFF, "R8 firmware top");
        lookup(20'h84000, "R8 hidden half mode 3");
        write_ctl(20'h2C000, 4'd1);
        lookup(20'h84000, "R8 hidden half mode 1");

        lookup(20'hE0000, "R9 window disabled");
        set_hw(1);
        lookup(20'hE0000, "R9 window start");
        lookup(20'hE8000, "R9 second half");
        lookup(20'hEFFFF, "R9 window end");
        lookup(20'hF0000, "R9 past window");
        load_entry(7, 1, 20'hE0000, 4'hA, 3'd3);
        lookup(20'hE0002, "R9 table over window");
        load_entry(7, 0, 20'hE0000, 4'hA, 3'd3);
        lookup(20'hE0002, "R4 cleared entry");

        // Constrained random tables and addresses
        for (int n = 0; n < 600; n++) begin
            if (n % 40 == 0) begin
                for (int k = 0; k < N_ENT; k++)
                    load_entry(k, ($urandom % 8) != 0, 20'($urandom),
                               4'(7 + $urandom % 5), 3'($urandom));
                write_ctl(20'h2C000, 4'($urandom % 4));
                set_hw(1'($urandom));
            end
            if ($urandom % 2 == 0) begin
                int k = int'($urandom % N_ENT);
                lookup(m_base[k] + 20'($urandom % 'h22000), "R3 random near base");
            end else begin
                lookup(20'($urandom), "R6 random address");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule